// File: doc/BRIEF.md
# SDRAM Bank State and Command Timing Guard

This block sits between a command source and a four-bank SDRAM. It watches each command the source presents, as a chip-select, row-strobe, column-strobe and write-enable pin tuple with a bank number, the address bit that selects auto-precharge or all-bank precharge, and a row address. In the same cycle it decides whether that command may go to the memory now. An accepted command updates the tracked state of the banks. A refused command changes nothing and is flagged on a separate reject output.

For each bank the guard keeps an open/closed flag, the open row, and down-counters. These enforce activate-to-column delay, minimum active time, activate-to-activate delay on one bank, and precharge recovery. A shared counter spaces activates to different banks. A read or write with auto-precharge arms a per-bank launch counter that closes the bank internally at the right moment. All delays are parameters counted in clock cycles.

Top module: `sdram_bank_guard`

## Requirements
- R1: Pin codes {cs_n,ras_n,cas_n,we_n} decode as follows: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0111 no-op, and any code with cs_n=1 is deselect. No-op and deselect are always granted and change no state. Mode set (0000) and burst stop (0110) are always rejected.
- R2: A granted activate opens the addressed bank and records its row. An activate to a bank that is already open is rejected.
- R3: A read or write to an open bank is granted only from RCD_CYC cycles after that bank's activate.
- R4: An activate to a bank is granted only from RC_CYC cycles after that bank's previous activate or after the last granted refresh.
- R5: An activate is granted only from RRD_CYC cycles after the previous granted activate to any bank.
- R6: An explicit precharge of an open bank is granted only from RAS_CYC cycles after its activate.
- R7: After a bank's precharge starts, explicit or internal, an activate to it is granted only from RP_CYC cycles later.
- R8: A precharge with the A10 input low closes only the addressed bank. With A10 high it closes every open bank, and it is rejected unless every open bank satisfies R6 and none has an auto-precharge pending. A precharge aimed at a closed bank is granted with no effect.
- R9: A read with A10 high, issued in cycle c to a bank activated in cycle a, starts the bank's internal precharge in cycle max(c+BURST_LEN, a+RAS_CYC). This start lies CAS_LAT-1 cycles before the last read beat. The bank reads as open through that cycle and as closed from the next.
- R10: A write with A10 high, issued in cycle c, starts the internal precharge in cycle max(c+BURST_LEN-1+WR_CYC, a+RAS_CYC). This is WR_CYC cycles after the last data beat. Reactivation follows R7.
- R11: While an auto-precharge is pending on a bank, reads, writes and precharges to that bank are rejected.
- R12: Refresh is granted only when every bank is closed and clear of R4 and R7 delays. A granted refresh leaves all banks closed.
- R13: Reads and writes to open, ready banks are granted on consecutive cycles, to the same or different banks.
- R14: A rejected command changes neither bank_open nor open_row. req_reject is high exactly when req_valid is high and the command is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A command is presented this cycle |
| req_cs_n | input | 1 | Command chip select, active low |
| req_ras_n | input | 1 | Command row strobe, active low |
| req_cas_n | input | 1 | Command column strobe, active low |
| req_we_n | input | 1 | Command write enable, active low |
| req_bank | input | BANK_W | Target bank number |
| req_a10 | input | 1 | Auto-precharge on read/write, all-bank on precharge |
| req_row | input | ROW_W | Row address for activate |
| req_grant | output | 1 | Command may issue this cycle; state is updated at the edge |
| req_reject | output | 1 | Command is presented but refused |
| bank_open | output | NUM_BANKS | Per-bank open flag |
| open_row | output | NUM_BANKS*ROW_W | Open row of each bank, bank b at bits b*ROW_W upward |

## Verification
A wrong counter load or a missed decrement appears at the ports as req_grant or req_reject flipping in the exact cycle a timing boundary is probed. For that reason each delay is swept one cycle either side of its limit. A wrong open flag or a misplaced auto-precharge launch shows on bank_open one cycle after the edge that should have changed it. It also shows as a later activate that is granted or refused in the wrong cycle. Each boundary is probed with a fresh reset, so one wrong state cannot hide another.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
  typedef enum logic [2:0] {
    OP_NOP,
    OP_ACT,
    OP_RD,
    OP_WR,
    OP_PRE,
    OP_REF,
    OP_BAD
  } op_e;
endpackage

// File: rtl/sdg_decode.sv
module sdg_decode
  import sdg_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output op_e  op
);
  always_comb begin
    if (cs_n) begin
      op = OP_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  op = OP_NOP;
        3'b011:  op = OP_ACT;
        3'b101:  op = OP_RD;
        3'b100:  op = OP_WR;
        3'b010:  op = OP_PRE;
        3'b001:  op = OP_REF;
        default: op = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/sdg_act_space.sv
module sdg_act_space #(
  parameter int RRD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go,
  output logic space_ok
);
  localparam int CW = $clog2(RRD_CYC + 1);
  typedef logic [CW-1:0] cnt_t;
  localparam cnt_t SAT = cnt_t'(RRD_CYC);

  cnt_t gap_q, gap_d;

  always_comb begin
    if (act_go)            gap_d = cnt_t'(RRD_CYC - 1);
    else if (gap_q != '0)  gap_d = gap_q - cnt_t'(1);
    else                   gap_d = gap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else        gap_q <= gap_d;
  end

  assign space_ok = (gap_q == '0);

  // independent age tracker for the spacing check
  cnt_t age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age_q <= SAT;
    else if (act_go)      age_q <= cnt_t'(1);
    else if (age_q != SAT) age_q <= age_q + cnt_t'(1);
  end

  // R5
  act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |-> (age_q >= SAT));
endmodule

// File: rtl/sdg_bank.sv
module sdg_bank #(
  parameter int ROW_W     = 11,
  parameter int RCD_CYC   = 3,
  parameter int RAS_CYC   = 6,
  parameter int RC_CYC    = 9,
  parameter int RP_CYC    = 3,
  parameter int WR_CYC    = 2,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_go,
  input  logic             col_go,
  input  logic             col_wr,
  input  logic             col_ap,
  input  logic             pre_go,
  input  logic             ref_go,
  input  logic [ROW_W-1:0] row_in,
  output logic             idle_ok,
  output logic             col_ok,
  output logic             pre_ok,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q
);
  // read: launch sits CAS_LAT-1 cycles ahead of the last beat on the bus
  localparam int RD_AP_DLY = (BURST_LEN + CAS_LAT - 1) - (CAS_LAT - 1);
  // write: launch sits WR_CYC cycles after the last data beat
  localparam int WR_AP_DLY = BURST_LEN - 1 + WR_CYC;
  localparam int SPAN = RCD_CYC + RAS_CYC + RC_CYC + RP_CYC + WR_AP_DLY + RD_AP_DLY;
  localparam int CW = $clog2(SPAN + 1);
  typedef logic [CW-1:0] cnt_t;
  localparam cnt_t SAT = cnt_t'(SPAN);

  function automatic cnt_t step_down(input cnt_t v);
    return (v == '0) ? '0 : v - cnt_t'(1);
  endfunction

  logic open_q, open_d;
  logic ap_q, ap_d;
  cnt_t rcd_q, rcd_d, ras_q, ras_d, rc_q, rc_d, rp_q, rp_d, apc_q, apc_d;
  logic ap_fire, pre_start;

  always_comb begin
    ap_fire   = ap_q && (apc_q == '0) && (ras_q == '0);
    pre_start = (pre_go && open_q) || ap_fire;

    open_d = open_q;
    if (act_go)         open_d = 1'b1;
    else if (pre_start) open_d = 1'b0;

    rcd_d = act_go ? cnt_t'(RCD_CYC - 1) : step_down(rcd_q);
    ras_d = act_go ? cnt_t'(RAS_CYC - 1) : step_down(ras_q);
    rc_d  = (act_go || ref_go) ? cnt_t'(RC_CYC - 1) : step_down(rc_q);
    rp_d  = pre_start ? cnt_t'(RP_CYC - 1) : step_down(rp_q);

    ap_d  = ap_q;
    apc_d = step_down(apc_q);
    if (col_go && col_ap) begin
      ap_d  = 1'b1;
      apc_d = col_wr ? cnt_t'(WR_AP_DLY - 1) : cnt_t'(RD_AP_DLY - 1);
    end else if (ap_fire) begin
      ap_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ap_q   <= 1'b0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rc_q   <= '0;
      rp_q   <= '0;
      apc_q  <= '0;
      row_q  <= '0;
    end else begin
      open_q <= open_d;
      ap_q   <= ap_d;
      rcd_q  <= rcd_d;
      ras_q  <= ras_d;
      rc_q   <= rc_d;
      rp_q   <= rp_d;
      apc_q  <= apc_d;
      if (act_go) row_q <= row_in;
    end
  end

  assign idle_ok = !open_q && (rp_q == '0) && (rc_q == '0);
  assign col_ok  = open_q && (rcd_q == '0) && !ap_q;
  assign pre_ok  = !open_q || ((ras_q == '0) && !ap_q);
  assign is_open = open_q;

  // independent ages: cycles since activate and since precharge start
  cnt_t act_age_q, idle_age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_age_q  <= '0;
      idle_age_q <= SAT;
    end else begin
      if (act_go)                 act_age_q <= cnt_t'(1);
      else if (act_age_q != SAT)  act_age_q <= act_age_q + cnt_t'(1);
      if (pre_start)              idle_age_q <= cnt_t'(1);
      else if (idle_age_q != SAT) idle_age_q <= idle_age_q + cnt_t'(1);
    end
  end

  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |=> (open_q && (row_q == $past(row_in))));
  // R3
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_go |-> (act_age_q >= cnt_t'(RCD_CYC)));
  // R6
  ras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start |-> (act_age_q >= cnt_t'(RAS_CYC)));
  // R7
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |-> (idle_age_q >= cnt_t'(RP_CYC)));
endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
  import sdg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 11,
  parameter int RCD_CYC   = 3,
  parameter int RAS_CYC   = 6,
  parameter int RC_CYC    = 9,
  parameter int RP_CYC    = 3,
  parameter int RRD_CYC   = 2,
  parameter int WR_CYC    = 2,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_cs_n,
  input  logic                       req_ras_n,
  input  logic                       req_cas_n,
  input  logic                       req_we_n,
  input  logic [BANK_W-1:0]          req_bank,
  input  logic                       req_a10,
  input  logic [ROW_W-1:0]           req_row,
  output logic                       req_grant,
  output logic                       req_reject,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_row
);
  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  op_e op;
  sdg_decode u_decode (
    .cs_n  (req_cs_n),
    .ras_n (req_ras_n),
    .cas_n (req_cas_n),
    .we_n  (req_we_n),
    .op    (op)
  );

  logic [NUM_BANKS-1:0] act_go, col_go, pre_go, idle_ok, col_ok, pre_ok;
  logic ref_go, space_ok, legal, accept;

  always_comb begin
    case (op)
      OP_NOP:        legal = 1'b1;
      OP_ACT:        legal = idle_ok[req_bank] && space_ok;
      OP_RD, OP_WR:  legal = col_ok[req_bank];
      OP_PRE:        legal = req_a10 ? (&pre_ok) : pre_ok[req_bank];
      OP_REF:        legal = &idle_ok;
      default:       legal = 1'b0;
    endcase
    accept = req_valid && legal;
    ref_go = accept && (op == OP_REF);
  end

  assign req_grant  = accept;
  assign req_reject = req_valid && !legal;

  sdg_act_space #(.RRD_CYC(RRD_CYC)) u_space (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .act_go   (|act_go),
    .space_ok (space_ok)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit       = (req_bank == BANK_W'(b));
    assign act_go[b] = accept && (op == OP_ACT) && hit;
    assign col_go[b] = accept && ((op == OP_RD) || (op == OP_WR)) && hit;
    assign pre_go[b] = accept && (op == OP_PRE) && (req_a10 || hit);

    sdg_bank #(
      .ROW_W     (ROW_W),
      .RCD_CYC   (RCD_CYC),
      .RAS_CYC   (RAS_CYC),
      .RC_CYC    (RC_CYC),
      .RP_CYC    (RP_CYC),
      .WR_CYC    (WR_CYC),
      .BURST_LEN (BURST_LEN),
      .CAS_LAT   (CAS_LAT)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .act_go  (act_go[b]),
      .col_go  (col_go[b]),
      .col_wr  (op == OP_WR),
      .col_ap  (req_a10),
      .pre_go  (pre_go[b]),
      .ref_go  (ref_go),
      .row_in  (req_row),
      .idle_ok (idle_ok[b]),
      .col_ok  (col_ok[b]),
      .pre_ok  (pre_ok[b]),
      .is_open (bank_open[b]),
      .row_q   (open_row[b*ROW_W +: ROW_W])
    );
  end

  // R8
  pre_all_closes_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_grant && (op == OP_PRE) && req_a10) |=> (bank_open == '0));
  // R12
  refresh_idle_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_grant && (op == OP_REF)) |-> (bank_open == '0));
  // R1
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && (op == OP_BAD)) |-> req_reject);
endmodule

// File: tb/sdram_bank_guard_bench.sv
module sdram_bank_guard_bench;
  localparam int NB = 4, ROW_W = 11;
  localparam int RCD = 3, RAS = 8, RC = 12, RP = 3, RRD = 2, WR = 2, BL = 4, CL = 3;
  localparam logic [3:0] P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100,
                         P_PRE = 4'b0010, P_REF = 4'b0001, P_NOP = 4'b0111,
                         P_MRS = 4'b0000, P_BST = 4'b0110, P_DES = 4'b1111;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_cs_n, req_ras_n, req_cas_n, req_we_n, req_a10;
  logic [1:0] req_bank;
  logic [ROW_W-1:0] req_row;
  logic req_grant, req_reject;
  logic [NB-1:0] bank_open;
  logic [NB*ROW_W-1:0] open_row;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sdram_bank_guard #(
    .NUM_BANKS(NB), .ROW_W(ROW_W), .RCD_CYC(RCD), .RAS_CYC(RAS), .RC_CYC(RC),
    .RP_CYC(RP), .RRD_CYC(RRD), .WR_CYC(WR), .BURST_LEN(BL), .CAS_LAT(CL)
  ) u_sdram_bank_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs_n(req_cs_n),
    .req_ras_n(req_ras_n), .req_cas_n(req_cas_n), .req_we_n(req_we_n),
    .req_bank(req_bank), .req_a10(req_a10), .req_row(req_row),
    .req_grant(req_grant), .req_reject(req_reject),
    .bank_open(bank_open), .open_row(open_row)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic issue(input logic [3:0] p, input int b, input bit a10, input int row,
                       input bit exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    {req_cs_n, req_ras_n, req_cas_n, req_we_n} = p;
    req_bank = b[1:0];
    req_a10 = a10;
    req_row = row[ROW_W-1:0];
    #1;
    chk((req_grant == exp) && (req_reject == !exp), tag,
        int'({req_grant, req_reject}), int'({exp, !exp}));
  endtask

  task automatic chk_open(input logic [NB-1:0] exp, input string tag);
    #1;
    chk(bank_open == exp, tag, int'(bank_open), int'(exp));
  endtask

  // auto-precharge case: column command at cycle tc after activate at 0
  task automatic ap_case(input bit is_wr, input int tc, input int d);
    int s, r;
    string tag;
    tag = is_wr ? "R10" : "R9";
    s = is_wr ? tc + BL - 1 + WR : tc + BL;
    if (s < RAS) s = RAS;
    r = (s + RP > RC) ? s + RP : RC;
    do_reset();
    issue(P_ACT, 0, 0, 7, 1, tag);
    idle(tc - 1);
    issue(is_wr ? P_WR : P_RD, 0, 1, 0, 1, tag);
    issue(P_RD, 0, 0, 0, 0, "R11 read during auto-precharge");
    issue(P_PRE, 0, 0, 0, 0, "R11 precharge during auto-precharge");
    idle(s - (tc + 2));
    chk_open(4'b0001, {tag, " open at launch cycle"});
    idle(1);
    chk_open(4'b0000, {tag, " closed after launch"});
    idle(d - s - 2);
    issue(P_ACT, 0, 0, 7, d >= r, {tag, "/R7 reactivate"});
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    {req_cs_n, req_ras_n, req_cas_n, req_we_n} = P_DES;
    req_bank = '0;
    req_a10 = 1'b0;
    req_row = '0;

    // reset state
    do_reset();
    #1;
    chk(bank_open == '0 && !req_grant && !req_reject, "reset state", int'(bank_open), 0);

    // R1 decode of non-bank codes
    issue(P_DES, 2, 1, 0, 1, "R1 deselect");
    issue(P_NOP, 1, 0, 0, 1, "R1 nop");
    issue(P_MRS, 0, 0, 0, 0, "R1 mode set rejected");
    issue(P_BST, 0, 0, 0, 0, "R1 burst stop rejected");
    idle(1);
    chk_open(4'b0000, "R1 no state change");

    // R2 / R14 activate and rejected re-activate
    do_reset();
    issue(P_ACT, 3, 0, 'h2A5, 1, "R2 activate");
    idle(RCD);
    #1;
    chk(bank_open == 4'b1000 && open_row[3*ROW_W +: ROW_W] == 11'h2A5, "R2 row recorded",
        int'(open_row[3*ROW_W +: ROW_W]), 'h2A5);
    issue(P_ACT, 3, 0, 'h111, 0, "R2 activate open bank");
    issue(P_RD, 0, 0, 0, 0, "R14 read to closed bank");
    idle(1);
    chk(open_row[3*ROW_W +: ROW_W] == 11'h2A5, "R14 row unchanged",
        int'(open_row[3*ROW_W +: ROW_W]), 'h2A5);
    chk_open(4'b1000, "R14 open flags unchanged");

    // R3 activate-to-column sweep
    for (int d = 1; d <= RCD + 1; d++) begin
      do_reset();
      issue(P_ACT, 0, 0, 1, 1, "R3");
      idle(d - 1);
      issue(P_RD, 0, 0, 0, d >= RCD, "R3 column after activate");
    end

    // R6 active-time sweep
    for (int d = RAS - 2; d <= RAS + 1; d++) begin
      do_reset();
      issue(P_ACT, 1, 0, 1, 1, "R6");
      idle(d - 1);
      issue(P_PRE, 1, 0, 0, d >= RAS, "R6 precharge after activate");
      idle(1);
      chk_open((d >= RAS) ? 4'b0000 : 4'b0010, "R6/R14 open after precharge try");
    end

    // R7 / R4 reactivation sweep after explicit precharge
    for (int d = 1; d <= RP + 2; d++) begin
      do_reset();
      issue(P_ACT, 2, 0, 1, 1, "R7");
      idle(RAS - 1);
      issue(P_PRE, 2, 0, 0, 1, "R7 precharge");
      idle(d - 1);
      issue(P_ACT, 2, 0, 3, (d >= RP) && (RAS + d >= RC), "R7/R4 reactivate");
    end

    // R4 refresh to activate
    for (int d = RC - 1; d <= RC; d++) begin
      do_reset();
      issue(P_REF, 0, 0, 0, 1, "R12 refresh all idle");
      idle(d - 1);
      issue(P_ACT, 1, 0, 4, d >= RC, "R4 activate after refresh");
    end

    // R5 activate spacing across banks
    for (int d = 1; d <= RRD + 1; d++) begin
      do_reset();
      issue(P_ACT, 0, 0, 1, 1, "R5");
      idle(d - 1);
      issue(P_ACT, 1, 0, 2, d >= RRD, "R5 second bank activate");
      idle(1);
      chk_open((d >= RRD) ? 4'b0011 : 4'b0001, "R5/R14 open flags");
    end

    // R8 single versus all-bank precharge
    do_reset();
    issue(P_ACT, 0, 0, 5, 1, "R8");
    idle(RRD - 1);
    issue(P_ACT, 2, 0, 9, 1, "R8");
    idle(RAS);
    issue(P_PRE, 2, 0, 0, 1, "R8 single precharge");
    idle(1);
    chk_open(4'b0001, "R8 only addressed bank closed");
    issue(P_PRE, 3, 1, 0, 1, "R8 all-bank precharge");
    idle(1);
    chk_open(4'b0000, "R8 all banks closed");

    do_reset();
    issue(P_ACT, 0, 0, 5, 1, "R8");
    idle(RAS - 1);
    issue(P_ACT, 1, 0, 6, 1, "R8");
    issue(P_PRE, 0, 1, 0, 0, "R8 all-bank with young bank");
    issue(P_PRE, 0, 0, 0, 1, "R8 single on ready bank");
    idle(1);
    chk_open(4'b0010, "R8 young bank still open");

    // R12 refresh with an open bank
    do_reset();
    issue(P_ACT, 1, 0, 3, 1, "R12");
    idle(1);
    issue(P_REF, 0, 0, 0, 0, "R12 refresh with open bank");
    idle(1);
    chk_open(4'b0010, "R12/R14 state kept");

    // R13 back-to-back column commands
    do_reset();
    issue(P_ACT, 0, 0, 1, 1, "R13");
    idle(RRD - 1);
    issue(P_ACT, 1, 0, 2, 1, "R13");
    idle(RCD);
    issue(P_RD, 0, 0, 0, 1, "R13 read b0");
    issue(P_WR, 0, 0, 0, 1, "R13 write b0");
    issue(P_RD, 1, 0, 0, 1, "R13 read b1");
    issue(P_WR, 1, 0, 0, 1, "R13 write b1");
    issue(P_RD, 0, 0, 0, 1, "R13 read b0 again");

    // R9 / R10 auto-precharge launch and reactivation
    for (int k = 0; k < 4; k++) begin
      bit w;
      int tc, s, r;
      w  = (k >= 2);
      tc = (k % 2 == 0) ? RCD : 6;
      s  = w ? tc + BL - 1 + WR : tc + BL;
      if (s < RAS) s = RAS;
      r = (s + RP > RC) ? s + RP : RC;
      ap_case(w, tc, r - 1);
      ap_case(w, tc, r);
    end

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule